// File: doc/BRIEF.md
# Latched Fault Supervisor with Coded Power-Good

This block is the sequencing and protection core of a single-phase buck controller. It watches the enable input and a supply-good flag from power-on reset. When both are high it runs a soft-start phase, and after a programmed delay it releases power-good. Throughout, it turns comparator flags for undervoltage, overvoltage, peak overcurrent, short circuit and over-temperature into run and force-off commands for the modulator and gate drivers.

Undervoltage, overvoltage, overcurrent and short-circuit faults stop the converter and keep it stopped. They are released only when enable falls or supply-good is lost. While stopped, the block drives a 2-bit code that picks the strength of the power-good pull-down, so a board probe can tell which fault occurred. Overcurrent must be seen on every PWM pulse for a whole time window before it counts as a fault. A short circuit must persist for a shorter window. Over-temperature only suspends switching and never latches. After an overvoltage latch, the low-side gate keeps acting as a crowbar with hysteresis.

All timing is counted in clock cycles through parameters, so a bench can run with short windows.

Top module: `fault_supervisor`

## Requirements
- R1: After reset, or while enIn or supplyOk is low, the outputs are pwmRun=0, forceOff=1, pgoodRel=0, lowSideOn=0 and pdCode=01 (weak pull-down).
- R2: If enIn and supplyOk are both high at a rising edge while the block is off, soft-start begins. pwmRun is 1 after that edge. pgoodRel rises and pdCode becomes 00 (released) PG_DLY_CYC rising edges later.
- R3: uvFlag is ignored during soft-start, which neither latches nor stops pwmRun. Once power-good is released, uvFlag high at an edge latches the fault with pdCode=01, pgoodRel=0 and pwmRun=0.
- R4: Overcurrent latches with pdCode=11 once ocFlag has been high on every pulseStb for OC_WIN_CYC cycles after the first flagged pulse. The latch is taken OC_WIN_CYC+1 edges after that pulse. A pulseStb with ocFlag low cancels the window, and the next flagged pulse starts a new one.
- R5: scFlag held high for SC_WIN_CYC consecutive edges latches with pdCode=11 at the next edge. A shorter burst has no effect.
- R6: ovRise high at an edge while running latches with pdCode=10. Under that latch, lowSideOn turns on at an edge where ovRise is high and turns off at an edge where ovAboveFall is low.
- R7: When faults coincide at one edge, short circuit or overcurrent (code 11) wins over overvoltage (10), which wins over undervoltage (01). Once latched, the code does not change when later faults arrive.
- R8: A latched fault, and its code, persists while enIn and supplyOk stay high, even with all fault flags cleared. It clears when either one is low at an edge, and a new soft-start follows.
- R9: While otFlag is high, pwmRun=0 and forceOff=1 in the same cycle, and lowSideOn=0. pgoodRel and pdCode are unchanged and nothing latches. The soft-start delay pauses for those cycles, and switching resumes when otFlag clears.
- R10: enIn low forces pwmRun to 0 in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enIn | input | 1 | Converter enable |
| supplyOk | input | 1 | Supply above power-on-reset threshold |
| uvFlag | input | 1 | Feedback below undervoltage threshold |
| ovRise | input | 1 | Feedback above overvoltage rising threshold |
| ovAboveFall | input | 1 | Feedback above overvoltage falling threshold |
| ocFlag | input | 1 | Sense current above overcurrent threshold |
| scFlag | input | 1 | Sense current above twice that threshold |
| otFlag | input | 1 | Die over temperature (hysteresis applied outside) |
| pulseStb | input | 1 | One-cycle strobe per PWM pulse |
| pwmRun | output | 1 | Modulator allowed to switch |
| forceOff | output | 1 | Both gate drives held off by normal control |
| lowSideOn | output | 1 | Low-side gate override (overvoltage crowbar) |
| pgoodRel | output | 1 | Power-good released (high impedance) |
| pdCode | output | 2 | Pull-down strength: 00 none, 01 weak, 10 medium, 11 strong |

## Verification
Most results are due one rising edge after the stimulus. This covers each latch and its code, the return to off, and the low-side toggles. pwmRun responds to enIn and otFlag within the same cycle. Power-good is due PG_DLY_CYC+1 edges after enable is applied, moved back by one edge for each over-temperature cycle. The overcurrent and short-circuit latches land OC_WIN_CYC+1 and SC_WIN_CYC+1 edges after the qualifying pulse or the first flagged edge. The bench drives on falling edges, samples on the falling edge before each drive, and places each check exactly at the first edge where the result may show and at the edge just before it.

// File: rtl/fs_pkg.sv
package fs_pkg;

  typedef enum logic [1:0] {
    PD_REL    = 2'b00,
    PD_WEAK   = 2'b01,
    PD_MED    = 2'b10,
    PD_STRONG = 2'b11
  } pdCode_e;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_SOFT  = 2'd1,
    ST_RUN   = 2'd2,
    ST_LATCH = 2'd3
  } supState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic ssCount;
    logic ssClear;
    logic qualEn;
  } ctlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic ssDone;
    logic ocTrip;
    logic scTrip;
  } dpStatus_t;

endpackage

// File: rtl/fs_dp.sv
module fs_dp
  import fs_pkg::*;
#(
  parameter int PG_DLY_CYC = 27500,
  parameter int OC_WIN_CYC = 200,
  parameter int SC_WIN_CYC = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ctlStrobe_t ctl,
  input  logic       pulseStb,
  input  logic       ocFlag,
  input  logic       scFlag,
  output dpStatus_t  status
);

  localparam int SS_W = $clog2(PG_DLY_CYC + 1);
  localparam int OC_W = $clog2(OC_WIN_CYC + 1);
  localparam int SC_W = $clog2(SC_WIN_CYC + 1);
  localparam logic [SS_W-1:0] SS_LAST = SS_W'(PG_DLY_CYC - 1);
  localparam logic [OC_W-1:0] OC_END  = OC_W'(OC_WIN_CYC);
  localparam logic [SC_W-1:0] SC_END  = SC_W'(SC_WIN_CYC);

  logic [SS_W-1:0] ssCnt;
  logic [OC_W-1:0] ocCnt;
  logic [SC_W-1:0] scCnt;
  logic            ocArmed;

  // soft-start delay counter, paused when ssCount is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssCnt <= '0;
    end else if (ctl.ssClear) begin
      ssCnt <= '0;
    end else if (ctl.ssCount && (ssCnt != SS_LAST)) begin
      ssCnt <= ssCnt + 1'b1;
    end
  end

  // overcurrent window: every pulse inside it must carry the flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocArmed <= 1'b0;
      ocCnt   <= '0;
    end else if (!ctl.qualEn) begin
      ocArmed <= 1'b0;
      ocCnt   <= '0;
    end else if (pulseStb && !ocFlag) begin
      ocArmed <= 1'b0;
      ocCnt   <= '0;
    end else if (pulseStb && ocFlag && !ocArmed) begin
      ocArmed <= 1'b1;
      ocCnt   <= '0;
    end else if (ocArmed && (ocCnt != OC_END)) begin
      ocCnt <= ocCnt + 1'b1;
    end
  end

  // short-circuit persistence counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scCnt <= '0;
    end else if (!ctl.qualEn || !scFlag) begin
      scCnt <= '0;
    end else if (scCnt != SC_END) begin
      scCnt <= scCnt + 1'b1;
    end
  end

  always_comb begin
    status.ssDone = (ssCnt == SS_LAST);
    status.ocTrip = ocArmed && (ocCnt == OC_END);
    status.scTrip = (scCnt == SC_END);
  end

  AST_OC_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ocArmed |-> (ocCnt <= OC_END)); // R4

  AST_OC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.qualEn && pulseStb && !ocFlag) |=> !status.ocTrip); // R4

  AST_SC_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.qualEn && !scFlag) |=> !status.scTrip); // R5

endmodule

// File: rtl/fs_ctrl.sv
module fs_ctrl
  import fs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enIn,
  input  logic       supplyOk,
  input  logic       uvFlag,
  input  logic       ovRise,
  input  logic       ovAboveFall,
  input  logic       otFlag,
  input  dpStatus_t  status,
  output ctlStrobe_t ctl,
  output logic       pwmRun,
  output logic       forceOff,
  output logic       lowSideOn,
  output logic       pgoodRel,
  output logic [1:0] pdCode
);

  supState_e state, stateNext;
  pdCode_e   faultCode, faultNext;
  logic      ovLs, ovLsNext;
  logic      live, active, faultHit;
  pdCode_e   faultPick;

  assign live   = enIn && supplyOk;
  assign active = (state == ST_SOFT) || (state == ST_RUN);

  // fault selection with fixed priority
  always_comb begin
    faultHit  = 1'b0;
    faultPick = PD_WEAK;
    if (status.ocTrip || status.scTrip) begin
      faultHit  = 1'b1;
      faultPick = PD_STRONG;
    end else if (ovRise) begin
      faultHit  = 1'b1;
      faultPick = PD_MED;
    end else if ((state == ST_RUN) && uvFlag) begin
      faultHit  = 1'b1;
      faultPick = PD_WEAK;
    end
  end

  always_comb begin
    stateNext = state;
    faultNext = faultCode;
    if (!live) begin
      stateNext = ST_OFF;
      faultNext = PD_WEAK;
    end else begin
      unique case (state)
        ST_OFF: stateNext = ST_SOFT;
        ST_SOFT, ST_RUN: begin
          if (faultHit) begin
            stateNext = ST_LATCH;
            faultNext = faultPick;
          end else if ((state == ST_SOFT) && status.ssDone && !otFlag) begin
            stateNext = ST_RUN;
          end
        end
        default: stateNext = ST_LATCH;
      endcase
    end
  end

  // crowbar hysteresis, only under an overvoltage latch
  always_comb begin
    if ((stateNext == ST_LATCH) && (faultNext == PD_MED)) begin
      ovLsNext = ovRise || (ovLs && ovAboveFall);
    end else begin
      ovLsNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OFF;
      faultCode <= PD_WEAK;
      ovLs      <= 1'b0;
    end else begin
      state     <= stateNext;
      faultCode <= faultNext;
      ovLs      <= ovLsNext;
    end
  end

  always_comb begin
    ctl.ssCount = (state == ST_SOFT) && !otFlag;
    ctl.ssClear = (state != ST_SOFT);
    ctl.qualEn  = active && live && !otFlag;
  end

  assign pwmRun    = active && live && !otFlag;
  assign forceOff  = !pwmRun;
  assign lowSideOn = ovLs && !otFlag;
  assign pgoodRel  = (state == ST_RUN);

  always_comb begin
    unique case (state)
      ST_RUN:   pdCode = PD_REL;
      ST_LATCH: pdCode = faultCode;
      default:  pdCode = PD_WEAK;
    endcase
  end

  AST_OFF_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> (!pgoodRel && (pdCode == PD_WEAK) && !lowSideOn)); // R1

  AST_EN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !enIn |=> (state == ST_OFF)); // R10

  AST_UV_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_SOFT) && live && !ovRise && !status.ocTrip && !status.scTrip)
      |=> (state != ST_LATCH)); // R3

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_LATCH) && live) |=> ((state == ST_LATCH) && (faultCode == $past(faultCode)))); // R8

  AST_LS_ONLY_OV: assert property (@(posedge clk) disable iff (!rst_n)
    lowSideOn |-> ((state == ST_LATCH) && (faultCode == PD_MED))); // R6

  AST_OT_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RUN) && otFlag && live && !uvFlag && !ovRise) |=> (state == ST_RUN)); // R9

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fs_pkg::*;
#(
  parameter int PG_DLY_CYC = 27500,
  parameter int OC_WIN_CYC = 200,
  parameter int SC_WIN_CYC = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enIn,
  input  logic       supplyOk,
  input  logic       uvFlag,
  input  logic       ovRise,
  input  logic       ovAboveFall,
  input  logic       ocFlag,
  input  logic       scFlag,
  input  logic       otFlag,
  input  logic       pulseStb,
  output logic       pwmRun,
  output logic       forceOff,
  output logic       lowSideOn,
  output logic       pgoodRel,
  output logic [1:0] pdCode
);

  ctlStrobe_t ctl;
  dpStatus_t  status;

  fs_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .enIn        (enIn),
    .supplyOk    (supplyOk),
    .uvFlag      (uvFlag),
    .ovRise      (ovRise),
    .ovAboveFall (ovAboveFall),
    .otFlag      (otFlag),
    .status      (status),
    .ctl         (ctl),
    .pwmRun      (pwmRun),
    .forceOff    (forceOff),
    .lowSideOn   (lowSideOn),
    .pgoodRel    (pgoodRel),
    .pdCode      (pdCode)
  );

  fs_dp #(
    .PG_DLY_CYC (PG_DLY_CYC),
    .OC_WIN_CYC (OC_WIN_CYC),
    .SC_WIN_CYC (SC_WIN_CYC)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .pulseStb (pulseStb),
    .ocFlag   (ocFlag),
    .scFlag   (scFlag),
    .status   (status)
  );

endmodule

// File: tb/tb_fault_supervisor.sv
module tb_fault_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int PG = 20;
  localparam int OCW = 12;
  localparam int SCW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enIn = 0, supplyOk = 0, uvFlag = 0, ovRise = 0, ovAboveFall = 0;
  logic ocFlag = 0, scFlag = 0, otFlag = 0, pulseStb = 0;
  logic pwmRun, forceOff, lowSideOn, pgoodRel;
  logic [1:0] pdCode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_supervisor #(.PG_DLY_CYC(PG), .OC_WIN_CYC(OCW), .SC_WIN_CYC(SCW)) dut (
    .clk(clk), .rst_n(rst_n), .enIn(enIn), .supplyOk(supplyOk), .uvFlag(uvFlag),
    .ovRise(ovRise), .ovAboveFall(ovAboveFall), .ocFlag(ocFlag), .scFlag(scFlag),
    .otFlag(otFlag), .pulseStb(pulseStb), .pwmRun(pwmRun), .forceOff(forceOff),
    .lowSideOn(lowSideOn), .pgoodRel(pgoodRel), .pdCode(pdCode)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearFlags();
    uvFlag = 0; ovRise = 0; ovAboveFall = 0; ocFlag = 0;
    scFlag = 0; otFlag = 0; pulseStb = 0;
  endtask

  task automatic goRun();
    clearFlags();
    supplyOk = 1; enIn = 0;
    step(2);
    enIn = 1;
    step(PG + 1);
    chk("R2", "pgoodRel in run", int'(pgoodRel), 1);
  endtask

  task automatic tReset();
    chk("R1", "pwmRun after reset", int'(pwmRun), 0);
    chk("R1", "forceOff after reset", int'(forceOff), 1);
    chk("R1", "pgoodRel after reset", int'(pgoodRel), 0);
    chk("R1", "pdCode after reset", int'(pdCode), 1);
    chk("R1", "lowSideOn after reset", int'(lowSideOn), 0);
    enIn = 1; supplyOk = 0;
    step(3);
    chk("R1", "pwmRun without supplyOk", int'(pwmRun), 0);
    chk("R1", "pdCode without supplyOk", int'(pdCode), 1);
  endtask

  task automatic tStart();
    enIn = 0; supplyOk = 1; clearFlags();
    step(2);
    enIn = 1;
    step(1);
    chk("R2", "pwmRun in soft-start", int'(pwmRun), 1);
    chk("R2", "pgoodRel in soft-start", int'(pgoodRel), 0);
    chk("R2", "pdCode in soft-start", int'(pdCode), 1);
    step(PG - 1);
    chk("R2", "pgoodRel one edge early", int'(pgoodRel), 0);
    step(1);
    chk("R2", "pgoodRel on time", int'(pgoodRel), 1);
    chk("R2", "pdCode released", int'(pdCode), 0);
  endtask

  task automatic tUv();
    clearFlags(); enIn = 0; supplyOk = 1;
    step(2);
    enIn = 1;
    step(3);
    uvFlag = 1;
    step(3);
    uvFlag = 0;
    chk("R3", "pwmRun with uv in soft-start", int'(pwmRun), 1);
    step(PG + 1 - 6);
    chk("R3", "pgoodRel despite uv in soft-start", int'(pgoodRel), 1);
    uvFlag = 1;
    step(1);
    uvFlag = 0;
    chk("R3", "pdCode uv latch", int'(pdCode), 1);
    chk("R3", "pgoodRel uv latch", int'(pgoodRel), 0);
    chk("R3", "pwmRun uv latch", int'(pwmRun), 0);
  endtask

  task automatic tOcFull();
    goRun();
    for (int i = 0; i <= OCW + 2; i++) begin
      if (i == OCW + 1) chk("R4", "pdCode before oc window end", int'(pdCode), 0);
      if (i == OCW + 2) begin
        chk("R4", "pdCode oc latch", int'(pdCode), 3);
        chk("R4", "pwmRun oc latch", int'(pwmRun), 0);
      end
      ocFlag = 1;
      pulseStb = (i % 3 == 0);
      step(1);
    end
    clearFlags();
  endtask

  task automatic tOcRestart();
    goRun();
    for (int i = 0; i <= 23; i++) begin
      if (i == OCW + 2) chk("R4", "pdCode after broken window", int'(pdCode), 0);
      if (i == 22) chk("R4", "pdCode before restarted window end", int'(pdCode), 0);
      if (i == 23) chk("R4", "pdCode restarted window latch", int'(pdCode), 3);
      ocFlag = (i != 6);
      pulseStb = (i % 3 == 0);
      step(1);
    end
    clearFlags();
  endtask

  task automatic tSc();
    goRun();
    scFlag = 1;
    step(SCW - 1);
    scFlag = 0;
    step(1);
    chk("R5", "pdCode after short sc burst", int'(pdCode), 0);
    step(2);
    for (int i = 0; i <= SCW + 1; i++) begin
      if (i == SCW) chk("R5", "pdCode one edge before sc latch", int'(pdCode), 0);
      if (i == SCW + 1) chk("R5", "pdCode sc latch", int'(pdCode), 3);
      scFlag = 1;
      step(1);
    end
    clearFlags();
  endtask

  task automatic tOv();
    goRun();
    ovRise = 1; ovAboveFall = 1;
    step(1);
    chk("R6", "pdCode ov latch", int'(pdCode), 2);
    chk("R6", "lowSideOn on ov", int'(lowSideOn), 1);
    chk("R6", "pwmRun ov latch", int'(pwmRun), 0);
    chk("R6", "pgoodRel ov latch", int'(pgoodRel), 0);
    ovRise = 0;
    step(1);
    chk("R6", "lowSideOn held above falling", int'(lowSideOn), 1);
    ovAboveFall = 0;
    step(1);
    chk("R6", "lowSideOn off below falling", int'(lowSideOn), 0);
    ovRise = 1; ovAboveFall = 1;
    step(1);
    chk("R6", "lowSideOn on again", int'(lowSideOn), 1);
    ovRise = 0; ovAboveFall = 0;
    step(1);
    chk("R6", "lowSideOn off again", int'(lowSideOn), 0);
    chk("R6", "pdCode kept ov", int'(pdCode), 2);
    clearFlags();
  endtask

  task automatic tPrio();
    goRun();
    uvFlag = 1; ovRise = 1; ovAboveFall = 1;
    step(1);
    chk("R7", "ov over uv", int'(pdCode), 2);
    clearFlags();
    scFlag = 1;
    step(SCW + 2);
    chk("R7", "first fault kept against sc", int'(pdCode), 2);
    clearFlags();
    goRun();
    for (int i = 0; i <= SCW; i++) begin
      scFlag = 1;
      if (i == SCW) begin
        ovRise = 1; ovAboveFall = 1;
      end
      step(1);
    end
    chk("R7", "sc over ov", int'(pdCode), 3);
    chk("R7", "no crowbar under sc latch", int'(lowSideOn), 0);
    clearFlags();
  endtask

  task automatic tClear();
    goRun();
    uvFlag = 1;
    step(1);
    uvFlag = 0;
    step(5);
    chk("R8", "latch held without flags", int'(pwmRun), 0);
    chk("R8", "code held without flags", int'(pdCode), 1);
    chk("R8", "pgood held low", int'(pgoodRel), 0);
    supplyOk = 0;
    step(1);
    supplyOk = 1;
    step(1);
    chk("R8", "restart after supply loss", int'(pwmRun), 1);
    step(PG);
    chk("R8", "pgood after restart", int'(pgoodRel), 1);
    uvFlag = 1;
    step(1);
    uvFlag = 0;
    enIn = 0;
    step(1);
    enIn = 1;
    step(1);
    chk("R8", "restart after enable toggle", int'(pwmRun), 1);
  endtask

  task automatic tOt();
    goRun();
    otFlag = 1;
    #1;
    chk("R9", "pwmRun same cycle ot", int'(pwmRun), 0);
    chk("R9", "forceOff same cycle ot", int'(forceOff), 1);
    step(1);
    chk("R9", "pgood unchanged in ot", int'(pgoodRel), 1);
    chk("R9", "pdCode unchanged in ot", int'(pdCode), 0);
    step(3);
    chk("R9", "still suspended", int'(pwmRun), 0);
    otFlag = 0;
    #1;
    chk("R9", "resume after ot", int'(pwmRun), 1);
    step(1);
    chk("R9", "no latch after ot", int'(pgoodRel), 1);
    enIn = 0;
    step(2);
    enIn = 1;
    step(3);
    otFlag = 1;
    step(5);
    otFlag = 0;
    step(PG - 3);
    chk("R9", "pgood delayed by ot pause", int'(pgoodRel), 0);
    step(1);
    chk("R9", "pgood after paused delay", int'(pgoodRel), 1);
  endtask

  task automatic tEnDrop();
    goRun();
    enIn = 0;
    #1;
    chk("R10", "pwmRun same cycle enable low", int'(pwmRun), 0);
    step(1);
    chk("R10", "pgood after enable low", int'(pgoodRel), 0);
    chk("R10", "pdCode after enable low", int'(pdCode), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    tReset();
    tStart();
    tUv();
    tOcFull();
    tOcRestart();
    tSc();
    tOv();
    tPrio();
    tClear();
    tOt();
    tEnDrop();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule